// File: doc/BRIEF.md
# Field-Interlaced Video DMA Write Address Generator

This block computes the memory write addresses for one video DMA channel that drains a 128-Dword FIFO of interlaced video into system memory. A programming set holds an odd-field start address, an even-field start address, a line stride, an upper-limit address, a burst length and a FIFO fill threshold. A field-start marker, qualified by a field-parity input, picks the start address. Each line-start marker moves the line origin forward by the stride. Inside a line, each accepted burst moves the write pointer forward by its own length.

Requests leave the block as a Dword-aligned byte address and a Dword count, under a valid/ready handshake. A request is raised only when the FIFO holds enough data. It never reaches the upper-limit address. When the pointer hits that limit, the channel stops, raises a sticky error flag and discards FIFO data until the next field. At every field boundary that closes an active field, the block pulses a done flag. In the same cycle it switches to any register values written during the field, so a new target can be programmed while a transfer runs.

The controller states are `ST_IDLE` (disabled or waiting for the first field), `ST_FILL` (waiting for the FIFO to reach the threshold), `ST_ISSUE` (request presented), `ST_SETTLE` (one cycle after an accept, so the FIFO level can update) and `ST_DROP` (limit reached, data discarded). The transitions are as follows:
- Clearing the enable sends the controller from any state to `ST_IDLE`.
- An enabled field start sends it from any state to `ST_FILL`.
- From `ST_FILL` it goes to `ST_DROP` when the pointer is at or above the limit, and otherwise to `ST_ISSUE` when the fill level reaches the threshold.
- From `ST_ISSUE` it goes to `ST_SETTLE` on ready.
- From `ST_SETTLE` it always returns to `ST_FILL`.
- `ST_DROP` holds until the next field start.

Top module: `vdma_addr_gen`

## Requirements
- R1: After reset, `req_valid`, `vtd`, `prot_err` and `drop_pop` are all low. The burst length and the threshold reset to their parameter defaults.
- R2: While `xfer_en` is low, no request is issued, field starts have no effect, and a register write takes effect in the working set one cycle later.
- R3: An enabled `field_start` with `field_odd`=1 starts the field at the odd-field base. With `field_odd`=0 it starts at the even-field base.
- R4: An enabled `line_start` during a field moves the line origin and the write pointer to the previous line origin plus the pitch. Each accepted request moves the write pointer forward by 4×`req_len` bytes.
- R5: A request is raised only when `fifo_level` is at least the threshold. Its length is the smaller of the burst length and the number of Dwords left before the limit address.
- R6: When the write pointer is at or above the limit, no further request is issued for that field. `prot_err` is set and stays set until the limit register is written. `drop_pop` is high in every cycle in which `fifo_level` is nonzero until the next field start.
- R7: `vtd` pulses for one cycle after an enabled `field_start` that closes an active field (controller not in `ST_IDLE`). It does not pulse for the first field after enabling.
- R8: Register writes made while `xfer_en` is high are held aside. They take effect at the next enabled field start.
- R9: The low two bits written to the odd base, the even base, the pitch and the limit are ignored.
- R10: `req_addr` is Dword aligned. `req_addr` and `req_len` are held stable while `req_valid` is high without `req_ready`, unless a field start or a disable intervenes.
- R11: The register selects on `cfg_addr` are 0 odd base, 1 even base, 2 pitch, 3 limit, 4 burst length and 5 threshold. Writes to 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_en | input | 1 | Transfer enable |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | AW | Register write data |
| field_start | input | 1 | Start-of-field marker |
| field_odd | input | 1 | Parity of the field being started |
| line_start | input | 1 | Start-of-line marker |
| fifo_level | input | LVLW | Dwords held in the channel FIFO |
| req_valid | output | 1 | Burst request present |
| req_ready | input | 1 | Burst request accepted |
| req_addr | output | AW | Byte address of the burst |
| req_len | output | LENW | Burst length in Dwords |
| vtd | output | 1 | Video transfer done pulse |
| prot_err | output | 1 | Sticky limit-reached flag |
| drop_pop | output | 1 | Discard one FIFO Dword |

## Verification
The in-line assertions check on every cycle that the following hold:
- requests stop after a disable;
- every burst ends at or below the limit, is aligned, and has a length between one and the burst setting;
- a pending request stays stable;
- the error flag is sticky;
- the working registers stay frozen during an enabled field.

The actual address sequence can only be shown by the bench scenarios, which sweep two pitches over both field parities and several lines with arithmetically computed addresses. The same applies to the done pulse timing, the deferred loading of a rewritten base, the clamped final burst and the data dropping at the limit.

// File: rtl/vdma_pkg.sv
package vdma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_ISSUE,
        ST_SETTLE,
        ST_DROP
    } vdma_state_e;

    localparam int unsigned REG_ODD_BASE  = 0;
    localparam int unsigned REG_EVEN_BASE = 1;
    localparam int unsigned REG_PITCH     = 2;
    localparam int unsigned REG_LIMIT     = 3;
    localparam int unsigned REG_BURST     = 4;
    localparam int unsigned REG_THRESH    = 5;
    localparam int unsigned NUM_ADDR_REGS = 4;

endpackage

// File: rtl/vdma_prog_regs.sv
module vdma_prog_regs #(
    parameter int unsigned AW        = 32,
    parameter int unsigned LENW      = 8,
    parameter int unsigned LVLW      = 8,
    parameter int unsigned BURST_RST = 16,
    parameter int unsigned THR_RST   = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            xfer_en,
    input  logic            field_start,
    input  logic            cfg_we,
    input  logic [2:0]      cfg_addr,
    input  logic [AW-1:0]   cfg_wdata,
    output logic [AW-1:0]   shd_odd_base,
    output logic [AW-1:0]   shd_even_base,
    output logic [AW-1:0]   act_pitch,
    output logic [AW-1:0]   act_limit,
    output logic [LENW-1:0] act_burst,
    output logic [LVLW-1:0] act_thresh,
    output logic            lim_wr
);
    import vdma_pkg::*;

    localparam int unsigned NA = NUM_ADDR_REGS;

    logic [AW-1:0]   shd_addr [NA];
    logic [AW-1:0]   act_addr [NA];
    logic [LENW-1:0] shd_burst;
    logic [LVLW-1:0] shd_thresh;
    logic            load_act;

    assign load_act = !xfer_en || field_start;

    genvar gi;
    generate
        for (gi = 0; gi < NA; gi++) begin : g_addr_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    shd_addr[gi] <= '0;
                end else if (cfg_we && (cfg_addr == 3'(gi))) begin
                    shd_addr[gi] <= {cfg_wdata[AW-1:2], 2'b00};
                end
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    act_addr[gi] <= '0;
                end else if (load_act) begin
                    act_addr[gi] <= shd_addr[gi];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shd_burst  <= LENW'(BURST_RST);
            shd_thresh <= LVLW'(THR_RST);
            act_burst  <= LENW'(BURST_RST);
            act_thresh <= LVLW'(THR_RST);
        end else begin
            if (cfg_we && (cfg_addr == 3'(REG_BURST))) begin
                shd_burst <= cfg_wdata[LENW-1:0];
            end
            if (cfg_we && (cfg_addr == 3'(REG_THRESH))) begin
                shd_thresh <= cfg_wdata[LVLW-1:0];
            end
            if (load_act) begin
                act_burst  <= shd_burst;
                act_thresh <= shd_thresh;
            end
        end
    end

    assign shd_odd_base  = shd_addr[REG_ODD_BASE];
    assign shd_even_base = shd_addr[REG_EVEN_BASE];
    assign act_pitch     = act_addr[REG_PITCH];
    assign act_limit     = act_addr[REG_LIMIT];
    assign lim_wr        = cfg_we && (cfg_addr == 3'(REG_LIMIT));

    // R8: working set frozen during an enabled field
    p_hold_shadow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_en && !field_start) |=> ($stable(act_limit) && $stable(act_pitch)
                                       && $stable(act_burst) && $stable(act_thresh)));

    // R9: stored addresses never carry low bits
    p_low_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (act_pitch[1:0] == 2'b00) && (act_limit[1:0] == 2'b00));

endmodule

// File: rtl/vdma_addr_track.sv
module vdma_addr_track #(
    parameter int unsigned AW   = 32,
    parameter int unsigned LENW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            field_go,
    input  logic [AW-1:0]   field_base,
    input  logic            line_go,
    input  logic [AW-1:0]   pitch,
    input  logic            adv,
    input  logic [LENW-1:0] adv_len,
    output logic [AW-1:0]   cur_addr
);
    logic [AW-1:0] line_base;
    logic [AW-1:0] next_line;
    logic [AW-1:0] adv_bytes;

    assign next_line = line_base + pitch;
    assign adv_bytes = AW'({adv_len, 2'b00});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_base <= '0;
            cur_addr  <= '0;
        end else if (field_go) begin
            line_base <= field_base;
            cur_addr  <= field_base;
        end else if (line_go) begin
            line_base <= next_line;
            cur_addr  <= next_line;
        end else if (adv) begin
            cur_addr  <= cur_addr + adv_bytes;
        end
    end

    // R4: pointer never falls behind its line origin within a line
    p_line_origin_r4: assert property (@(posedge clk) disable iff (!rst_n)
        line_go |=> (cur_addr == line_base));

endmodule

// File: rtl/vdma_burst_fsm.sv
module vdma_burst_fsm #(
    parameter int unsigned AW   = 32,
    parameter int unsigned LENW = 8,
    parameter int unsigned LVLW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            xfer_en,
    input  logic            field_start,
    input  logic            line_start,
    input  logic [LVLW-1:0] fifo_level,
    input  logic [AW-1:0]   cur_addr,
    input  logic [AW-1:0]   act_limit,
    input  logic [LENW-1:0] act_burst,
    input  logic [LVLW-1:0] act_thresh,
    input  logic            lim_wr,
    input  logic            req_ready,
    output logic            req_valid,
    output logic [AW-1:0]   req_addr,
    output logic [LENW-1:0] req_len,
    output logic            field_go,
    output logic            line_go,
    output logic            adv,
    output logic            vtd,
    output logic            prot_err,
    output logic            drop_pop
);
    import vdma_pkg::*;

    vdma_state_e   state, nxt;
    logic [AW-1:0] room_b;
    logic [AW-1:0] room_dw;
    logic          at_lim;
    logic [LENW-1:0] len_calc;

    assign at_lim  = (cur_addr >= act_limit);
    assign room_b  = act_limit - cur_addr;
    assign room_dw = room_b >> 2;

    always_comb begin
        if (room_dw < AW'(act_burst)) begin
            len_calc = room_dw[LENW-1:0];
        end else begin
            len_calc = act_burst;
        end
    end

    always_comb begin
        nxt = state;
        if (!xfer_en) begin
            nxt = ST_IDLE;
        end else if (field_start) begin
            nxt = ST_FILL;
        end else begin
            unique case (state)
                ST_IDLE:   nxt = ST_IDLE;
                ST_FILL: begin
                    if (at_lim) begin
                        nxt = ST_DROP;
                    end else if (fifo_level >= act_thresh) begin
                        nxt = ST_ISSUE;
                    end
                end
                ST_ISSUE:  if (req_ready) nxt = ST_SETTLE;
                ST_SETTLE: nxt = ST_FILL;
                ST_DROP:   nxt = ST_DROP;
                default:   nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_addr <= '0;
            req_len  <= '0;
            vtd      <= 1'b0;
            prot_err <= 1'b0;
        end else begin
            if ((nxt == ST_ISSUE) && (state != ST_ISSUE)) begin
                req_addr <= cur_addr;
                req_len  <= len_calc;
            end
            vtd <= xfer_en && field_start && (state != ST_IDLE);
            if ((state == ST_FILL) && (nxt == ST_DROP)) begin
                prot_err <= 1'b1;
            end else if (lim_wr) begin
                prot_err <= 1'b0;
            end
        end
    end

    always_comb begin
        req_valid = (state == ST_ISSUE);
        drop_pop  = (state == ST_DROP) && (fifo_level != '0);
        field_go  = xfer_en && field_start;
        line_go   = xfer_en && line_start && !field_start && (state != ST_IDLE);
        adv       = (state == ST_ISSUE) && req_ready && xfer_en && !field_start;
    end

    // R2: disable silences the request side
    p_no_req_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_en |=> !req_valid);

    // R5 / R6: every burst ends at or below the limit
    p_below_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ({1'b0, req_addr} + {1'b0, AW'({req_len, 2'b00})} <= {1'b0, act_limit}));

    // R5: burst length within the programmed setting and never empty
    p_len_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ((req_len <= act_burst) && (req_len != '0)));

    // R10: request held until accepted
    p_stable_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready && xfer_en && !field_start)
            |=> (req_valid && $stable(req_addr) && $stable(req_len)));

    // R10: Dword alignment
    p_aligned_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_addr[1:0] == 2'b00));

    // R6: sticky error until the limit is rewritten
    p_prot_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_err && !lim_wr) |=> prot_err);

    // R6: dropping and requesting are exclusive
    p_drop_no_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        drop_pop |-> !req_valid);

    // R7: done is a single-cycle pulse per field boundary
    p_vtd_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        vtd |-> $past(field_start));

endmodule

// File: rtl/vdma_addr_gen.sv
module vdma_addr_gen #(
    parameter int unsigned AW        = 32,
    parameter int unsigned FIFO_DW   = 128,
    parameter int unsigned BURST_RST = 16,
    parameter int unsigned THR_RST   = 16,
    parameter int unsigned LENW      = $clog2(FIFO_DW + 1),
    parameter int unsigned LVLW      = $clog2(FIFO_DW + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            xfer_en,
    input  logic            cfg_we,
    input  logic [2:0]      cfg_addr,
    input  logic [AW-1:0]   cfg_wdata,
    input  logic            field_start,
    input  logic            field_odd,
    input  logic            line_start,
    input  logic [LVLW-1:0] fifo_level,
    output logic            req_valid,
    input  logic            req_ready,
    output logic [AW-1:0]   req_addr,
    output logic [LENW-1:0] req_len,
    output logic            vtd,
    output logic            prot_err,
    output logic            drop_pop
);
    logic [AW-1:0]   shd_odd_base;
    logic [AW-1:0]   shd_even_base;
    logic [AW-1:0]   act_pitch;
    logic [AW-1:0]   act_limit;
    logic [LENW-1:0] act_burst;
    logic [LVLW-1:0] act_thresh;
    logic            lim_wr;
    logic [AW-1:0]   field_base;
    logic [AW-1:0]   cur_addr;
    logic            field_go;
    logic            line_go;
    logic            adv;

    assign field_base = field_odd ? shd_odd_base : shd_even_base;

    vdma_prog_regs #(
        .AW(AW), .LENW(LENW), .LVLW(LVLW),
        .BURST_RST(BURST_RST), .THR_RST(THR_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .xfer_en(xfer_en), .field_start(field_start),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .shd_odd_base(shd_odd_base), .shd_even_base(shd_even_base),
        .act_pitch(act_pitch), .act_limit(act_limit),
        .act_burst(act_burst), .act_thresh(act_thresh), .lim_wr(lim_wr)
    );

    vdma_addr_track #(.AW(AW), .LENW(LENW)) u_track (
        .clk(clk), .rst_n(rst_n),
        .field_go(field_go), .field_base(field_base),
        .line_go(line_go), .pitch(act_pitch),
        .adv(adv), .adv_len(req_len), .cur_addr(cur_addr)
    );

    vdma_burst_fsm #(.AW(AW), .LENW(LENW), .LVLW(LVLW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .xfer_en(xfer_en),
        .field_start(field_start), .line_start(line_start),
        .fifo_level(fifo_level), .cur_addr(cur_addr),
        .act_limit(act_limit), .act_burst(act_burst), .act_thresh(act_thresh),
        .lim_wr(lim_wr), .req_ready(req_ready),
        .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len),
        .field_go(field_go), .line_go(line_go), .adv(adv),
        .vtd(vtd), .prot_err(prot_err), .drop_pop(drop_pop)
    );

    // R1: outputs quiet out of reset
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!req_valid && !vtd && !prot_err));

endmodule

// File: tb/test_vdma_addr_gen.sv
module test_vdma_addr_gen;
    localparam int AW = 32;
    localparam int LENW = 8;
    localparam int LVLW = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            xfer_en = 1'b0;
    logic            cfg_we = 1'b0;
    logic [2:0]      cfg_addr = '0;
    logic [AW-1:0]   cfg_wdata = '0;
    logic            field_start = 1'b0;
    logic            field_odd = 1'b0;
    logic            line_start = 1'b0;
    logic [LVLW-1:0] fifo_level = '0;
    logic            req_valid;
    logic            req_ready = 1'b0;
    logic [AW-1:0]   req_addr;
    logic [LENW-1:0] req_len;
    logic            vtd;
    logic            prot_err;
    logic            drop_pop;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    vdma_addr_gen i_vdma_addr_gen (
        .clk(clk), .rst_n(rst_n), .xfer_en(xfer_en),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .field_start(field_start), .field_odd(field_odd), .line_start(line_start),
        .fifo_level(fifo_level), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .vtd(vtd),
        .prot_err(prot_err), .drop_pop(drop_pop)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [AW-1:0] d);
        cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic fld(input bit odd, output bit v);
        field_start = 1'b1; field_odd = odd;
        @(negedge clk);
        v = vtd;
        field_start = 1'b0;
    endtask

    task automatic lin();
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
    endtask

    task automatic take_req(input logic [AW-1:0] ea, input int el, input string tag);
        int n = 0;
        while (!req_valid && n < 40) begin
            @(negedge clk);
            n++;
        end
        chk(req_valid, {tag, " valid"}, req_valid, 1);
        chk(req_addr == ea, {tag, " addr"}, req_addr, ea);
        chk(req_len == LENW'(el), {tag, " len"}, req_len, el);
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
    endtask

    task automatic quiet(input int n, input string tag);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (req_valid) seen++;
        end
        chk(seen == 0, tag, seen, 0);
    endtask

    initial begin
        bit v;
        logic [AW-1:0] base, eff, a0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!req_valid && !vtd && !prot_err && !drop_pop, "R1 outputs",
            {req_valid, vtd, prot_err, drop_pop}, 0);

        // R11 register map, R9 low bits
        wr(0, 32'h1000);
        wr(1, 32'h4002);
        wr(3, 32'h10000);
        wr(4, 4);
        wr(5, 4);
        wr(6, 32'hFFFF_FFFF);
        wr(7, 32'hFFFF_FFFF);

        // R2 disabled: field starts and fill do nothing
        fifo_level = 8;
        fld(1, v);
        chk(!v, "R2 vtd while disabled", v, 0);
        quiet(10, "R2 no request while disabled");
        fifo_level = 0;

        // Sweep: two pitches, both parities, three lines of two bursts
        for (int p = 0; p < 2; p++) begin
            xfer_en = 1'b0;
            wr(2, p ? 32'h103 : 32'h40);
            eff = p ? 32'h100 : 32'h40;
            fifo_level = 0;
            xfer_en = 1'b1;
            @(negedge clk);
            for (int f = 0; f < 2; f++) begin
                fld(f == 0, v);
                chk(v == (f == 1), "R7 vtd at field boundary", v, f == 1);
                base = (f == 0) ? 32'h1000 : 32'h4000;
                fifo_level = 4;
                for (int ln = 0; ln < 3; ln++) begin
                    for (int k = 0; k < 2; k++) begin
                        take_req(base + ln * eff + k * 16, 4,
                                 (ln == 0 && k == 0) ? "R3 R9 R11 field base" : "R4 line step");
                    end
                    fifo_level = 0;
                    repeat (3) @(negedge clk);
                    if (ln < 2) lin();
                    fifo_level = 4;
                end
                fifo_level = 0;
                repeat (2) @(negedge clk);
            end
            xfer_en = 1'b0;
            @(negedge clk);
        end

        // R5 threshold, R10 stability
        xfer_en = 1'b1;
        fld(1, v);
        chk(!v, "R7 no vtd on first field", v, 0);
        fifo_level = 3;
        quiet(10, "R5 below threshold");
        fifo_level = 4;
        while (!req_valid) @(negedge clk);
        a0 = req_addr;
        repeat (5) @(negedge clk);
        chk(req_valid && req_addr == a0, "R10 held until ready", req_addr, a0);
        take_req(32'h1000, 4, "R5 at threshold");
        fifo_level = 0;
        xfer_en = 1'b0;
        @(negedge clk);

        // R6 protection limit and clamped length
        wr(3, 32'h1018);
        xfer_en = 1'b1;
        fld(1, v);
        fifo_level = 4;
        take_req(32'h1000, 4, "R6 first");
        take_req(32'h1010, 2, "R5 clamp to limit");
        repeat (5) @(negedge clk);
        chk(prot_err, "R6 prot_err set", prot_err, 1);
        chk(drop_pop, "R6 drop while data", drop_pop, 1);
        chk(!req_valid, "R6 no request at limit", req_valid, 0);
        fifo_level = 0;
        @(negedge clk);
        chk(!drop_pop, "R6 no drop when empty", drop_pop, 0);
        fld(1, v);
        chk(v, "R7 vtd after dropped field", v, 1);
        fifo_level = 4;
        take_req(32'h1000, 4, "R6 new field resumes");
        fifo_level = 0;
        chk(prot_err, "R6 sticky", prot_err, 1);
        wr(3, 32'h10000);
        chk(!prot_err, "R6 cleared by limit write", prot_err, 0);
        xfer_en = 1'b0;
        @(negedge clk);

        // R8 shadow hold
        xfer_en = 1'b1;
        fld(1, v);
        fifo_level = 4;
        take_req(32'h1000, 4, "R8 before rewrite");
        fifo_level = 0;
        wr(0, 32'h2000);
        repeat (3) @(negedge clk);
        fifo_level = 4;
        take_req(32'h1010, 4, "R8 old base kept in field");
        fifo_level = 0;
        repeat (3) @(negedge clk);
        fld(1, v);
        fifo_level = 4;
        take_req(32'h2000, 4, "R8 new base at field start");
        fifo_level = 0;
        repeat (3) @(negedge clk);
        fld(0, v);
        fifo_level = 4;
        take_req(32'h4000, 4, "R3 even base");
        fifo_level = 0;
        xfer_en = 1'b0;
        repeat (3) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule